// File: doc/BRIEF.md
# Four-Phase Input Edge Phase Monitor

This block accepts an external signal that has already been captured on four phases of the event clock, at 0°, 90°, 180° and 270°. It re-registers the four captures into the event clock domain through a synchroniser chain, so that each cycle yields one coherent four-sample snapshot. Software chooses the phase sample that drives the internal logic by writing a 2-bit select.

The block also records where within the clock period the last rising edge and the last falling edge fell. Each position is held as a 4-bit thermometer code, and each kind of edge has its own reset value. A clear strobe restores both codes. Software reads the two codes to find a sampling point well away from the signal's transitions, then programs the select to match.

Top module: `edge_phase_mon`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sel_out` becomes 0, `rise_pos` becomes 4'b0000 and `fall_pos` becomes 4'b1111.
- R2: Bit i of `phase_smp` is the sample taken at phase i×90°. `sel_out` carries the sample chosen by `phase_sel`: 0 selects 0°, 1 selects 90°, 2 selects 180° and 3 selects 270°. A change on `phase_smp` reaches `sel_out` after SYNC_STAGES+1 rising clock edges. A change on `phase_sel` reaches it after one edge.
- R3: After a clean rising edge, `rise_pos` reads 4'b1111 if the edge fell between 270° of the previous cycle and 0°, 4'b0111 if it fell between 0° and 90°, 4'b0011 for 90°–180°, and 4'b0001 for 180°–270°.
- R4: After a clean falling edge, `fall_pos` reads 4'b0000 if the edge fell between 270° of the previous cycle and 0°, 4'b1000 for 0°–90°, 4'b1100 for 90°–180°, and 4'b1110 for 180°–270°.
- R5: Each cycle the block examines the five-sample sequence formed by the previous snapshot's 270° bit followed by the current snapshot's 0°, 90°, 180° and 270° bits. Any adjacent 0→1 pair is a rising edge. Any adjacent 1→0 pair is a falling edge. A detected edge loads the matching register with {s0°, s90°, s180°, s270°}, so bit 3 holds the 0° sample and bit 0 holds the 270° sample.
- R6: When `mon_clr` is high at a clock edge, `rise_pos` becomes 4'b0000 and `fall_pos` becomes 4'b1111 at that edge. The clear takes priority over an edge detected in the same cycle.
- R7: In a cycle with no detected edge of a given kind and no clear, that kind's register keeps its value, however many cycles pass.
- R8: A snapshot that holds both a rising and a falling transition (a short pulse or a short gap inside one period) updates both registers in the same cycle with the same pattern.
- R9: The edge position registers show an edge present on `phase_smp` after SYNC_STAGES+1 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_smp | input | 4 | Input captured at 0°, 90°, 180°, 270° (bit 0 to bit 3) |
| phase_sel | input | 2 | Selects the phase sample that drives `sel_out` |
| mon_clr | input | 1 | Clear strobe for both edge position registers |
| sel_out | output | 1 | Selected, synchronised input sample |
| rise_pos | output | 4 | Thermometer code of the last rising edge position |
| fall_pos | output | 4 | Thermometer code of the last falling edge position |

## Verification
The hardest situations to create from the ports are the ones where edge detection depends on the previous cycle. One is an edge at the boundary between 270° and 0°, which only the previous snapshot's last bit reveals. The other is a period that holds both a rising and a falling transition. Directed sequences drive a steady level and then a full-period step, which produces the boundary codes. Other directed sequences drive mid-period pulses and gaps, which produce the double update, including one that lands together with a clear. A long seeded random run then mixes thermometer steps, arbitrary glitch patterns, select changes and occasional clears, and checks every cycle against the bench's own model of the edge rule.

// File: rtl/edge_phase_mon_pkg.sv
// Package: shared constants and types for the four-phase edge phase monitor.
// Assumes exactly four sampling phases, in order 0, 90, 180, 270 degrees.
package edge_phase_mon_pkg;
    localparam int NUM_PHASES = 4;
    localparam int SEL_W      = $clog2(NUM_PHASES);

    typedef logic [NUM_PHASES-1:0] phase_vec_t;

    localparam phase_vec_t RISE_IDLE = 4'b0000;
    localparam phase_vec_t FALL_IDLE = 4'b1111;
endpackage

// File: rtl/edge_phase_mon_sync.sv
// Module: multi-stage synchroniser for a vector of phase samples.
// Every bit moves through the same number of stages, so each output word
// is one coherent snapshot. Assumes STAGES >= 1.
module edge_phase_mon_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw samples into the event clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            // Move the snapshot one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/edge_phase_mon_select.sv
// Module: registered selection of one phase sample from the snapshot.
// Assumes the snapshot is already in the event clock domain.
module edge_phase_mon_select
    import edge_phase_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  phase_vec_t       snap,
    input  logic [SEL_W-1:0] sel,
    output logic             sel_out
);
    // Register the chosen phase bit as the block's logic signal.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_out <= 1'b0;
        else        sel_out <= snap[sel];
    end
endmodule

// File: rtl/edge_phase_mon_edge.sv
// Module: rising/falling edge position recorder.
// Joins the previous snapshot's last sample to the current snapshot,
// looks for transitions, and loads the snapshot (bit reversed, so bit 3 is
// the 0 degree sample) into the rising or falling register. Clear has priority.
module edge_phase_mon_edge
    import edge_phase_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_vec_t snap,
    input  logic       clr,
    output phase_vec_t rise_q,
    output phase_vec_t fall_q
);
    logic                  last_q;
    logic [NUM_PHASES:0]   seq;
    logic [NUM_PHASES-1:0] up_t;
    logic [NUM_PHASES-1:0] dn_t;
    logic                  rise_hit;
    logic                  fall_hit;
    phase_vec_t            pos_code;

    // Time-ordered sequence: previous 270 degree sample, then 0..270 now.
    assign seq = {snap, last_q};

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_trans
        assign up_t[i]                  = ~seq[i] &  seq[i+1];
        assign dn_t[i]                  =  seq[i] & ~seq[i+1];
        assign pos_code[NUM_PHASES-1-i] = snap[i];
    end

    assign rise_hit = |up_t;
    assign fall_hit = |dn_t;

    // Remember the latest-phase sample for the next cycle's comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= snap[NUM_PHASES-1];
    end

    // Update the rising edge position register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) rise_q <= RISE_IDLE;
        else if (rise_hit) rise_q <= pos_code;
    end

    // Update the falling edge position register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) fall_q <= FALL_IDLE;
        else if (fall_hit) fall_q <= pos_code;
    end

    // R6
    clear_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rise_q == RISE_IDLE && fall_q == FALL_IDLE));

    // R7
    rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !rise_hit) |=> $stable(rise_q));

    // R7
    fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !fall_hit) |=> $stable(fall_q));

    // R3
    rise_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !last_q && snap == 4'b1111) |=> (rise_q == 4'b1111));

    // R4
    fall_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && last_q && snap == 4'b0000) |=> (fall_q == 4'b0000));
endmodule

// File: rtl/edge_phase_mon.sv
// Module: top level of the four-phase input edge phase monitor.
// Synchronises four phase samples, drives the selected one out, and
// records rising/falling edge positions. Assumes phase_smp bit i was
// sampled at i*90 degrees of the event clock.
module edge_phase_mon
    import edge_phase_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] phase_smp,
    input  logic [1:0] phase_sel,
    input  logic       mon_clr,
    output logic       sel_out,
    output logic [3:0] rise_pos,
    output logic [3:0] fall_pos
);
    phase_vec_t snap;

    edge_phase_mon_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (NUM_PHASES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (phase_smp),
        .dout  (snap)
    );

    edge_phase_mon_select u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .snap    (snap),
        .sel     (phase_sel),
        .sel_out (sel_out)
    );

    edge_phase_mon_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .snap   (snap),
        .clr    (mon_clr),
        .rise_q (rise_pos),
        .fall_q (fall_pos)
    );

    // R2
    sel_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap == 4'b1111) |=> sel_out);

    // R2
    sel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap == 4'b0000) |=> !sel_out);
endmodule

// File: tb/tb_edge_phase_mon.sv
// Bench: directed corner cases plus seeded random stimulus, checked
// every cycle against a model built from the requirements.
module tb_edge_phase_mon;
    localparam int S = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] phase_smp;
    logic [1:0] phase_sel;
    logic       mon_clr;
    logic       sel_out;
    logic [3:0] rise_pos;
    logic [3:0] fall_pos;

    int tests  = 0;
    int failed = 0;

    logic [3:0] hist [0:S+1];
    logic [3:0] exp_rise;
    logic [3:0] exp_fall;
    logic       exp_sel;

    edge_phase_mon #(.SYNC_STAGES(S)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_smp (phase_smp),
        .phase_sel (phase_sel),
        .mon_clr   (mon_clr),
        .sel_out   (sel_out),
        .rise_pos  (rise_pos),
        .fall_pos  (fall_pos)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        tests++;
        failed++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    // Rising edge present in {prev, s0, s1, s2, s3}.
    function automatic logic has_rise(input logic p, input logic [3:0] x);
        logic [4:0] q;
        q = {x, p};
        for (int i = 0; i < 4; i++) if (!q[i] && q[i+1]) return 1'b1;
        return 1'b0;
    endfunction

    // Falling edge present in {prev, s0, s1, s2, s3}.
    function automatic logic has_fall(input logic p, input logic [3:0] x);
        logic [4:0] q;
        q = {x, p};
        for (int i = 0; i < 4; i++) if (q[i] && !q[i+1]) return 1'b1;
        return 1'b0;
    endfunction

    // Position code: bit 3 is the 0 degree sample.
    function automatic logic [3:0] pos_of(input logic [3:0] x);
        return {x[0], x[1], x[2], x[3]};
    endfunction

    task automatic check4(input string tag, input string what,
                          input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update the model at posedge, compare at next negedge.
    task automatic step(input logic [3:0] v, input logic [1:0] sel,
                        input logic clr, input string tag);
        logic [3:0] x;
        logic       p;
        phase_smp = v;
        phase_sel = sel;
        mon_clr   = clr;
        @(posedge clk);
        for (int k = S + 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = v;
        x = hist[S];
        p = hist[S+1][3];
        exp_sel = x[sel];
        if (clr) begin
            exp_rise = 4'b0000;
            exp_fall = 4'b1111;
        end else begin
            if (has_rise(p, x)) exp_rise = pos_of(x);
            if (has_fall(p, x)) exp_fall = pos_of(x);
        end
        @(negedge clk);
        check4(tag, "sel_out", {3'b000, sel_out}, {3'b000, exp_sel});
        check4(tag, "rise_pos", rise_pos, exp_rise);
        check4(tag, "fall_pos", fall_pos, exp_fall);
    endtask

    task automatic idle(input logic [3:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) step(v, 2'd0, 1'b0, tag);
    endtask

    initial begin
        logic [3:0] rise_pat [4];
        logic [3:0] fall_pat [4];
        logic [3:0] lvl;
        logic [3:0] v;
        int         r;
        void'($urandom(32'd1234));
        // Snapshot values (bit i = phase i*90): edge 270-0, 0-90, 90-180, 180-270.
        rise_pat[0] = 4'b1111; rise_pat[1] = 4'b1110;
        rise_pat[2] = 4'b1100; rise_pat[3] = 4'b1000;
        fall_pat[0] = 4'b0000; fall_pat[1] = 4'b0001;
        fall_pat[2] = 4'b0011; fall_pat[3] = 4'b0111;

        rst_n = 1'b0; phase_smp = '0; phase_sel = '0; mon_clr = 1'b0;
        for (int k = 0; k <= S + 1; k++) hist[k] = '0;
        exp_rise = 4'b0000; exp_fall = 4'b1111; exp_sel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check4("R1", "sel_out", {3'b000, sel_out}, 4'b0000);
        check4("R1", "rise_pos", rise_pos, 4'b0000);
        check4("R1", "fall_pos", fall_pos, 4'b1111);
        rst_n = 1'b1;

        // R9: latency of an edge through to the registers
        idle(4'b0000, 3, "R9");
        step(4'b1111, 2'd0, 1'b0, "R9");
        check4("R9", "rise_pos early", rise_pos, 4'b0000);
        idle(4'b1111, S, "R9");
        check4("R9", "rise_pos landed", rise_pos, 4'b1111);

        // R3 and R4: each edge position, with steady levels in between (R7)
        for (int k = 0; k < 4; k++) begin
            idle(4'b0000, 4, "R7");
            step(rise_pat[k], 2'd0, 1'b0, "R3");
            idle(4'b1111, 4, "R3");
            step(fall_pat[k], 2'd0, 1'b0, "R4");
            idle(4'b0000, 4, "R4");
        end

        // R7: long idle keeps both registers
        idle(4'b0000, 40, "R7");

        // R8: pulse and gap within one period
        step(4'b0110, 2'd1, 1'b0, "R8");
        idle(4'b0000, 4, "R8");
        idle(4'b1111, 4, "R8");
        step(4'b1001, 2'd2, 1'b0, "R8");
        idle(4'b1111, 4, "R8");

        // R5: falling edge using the previous cycle's last sample
        step(4'b1110, 2'd0, 1'b0, "R5");
        idle(4'b0000, 4, "R5");

        // R6: clear, and a clear landing with a detected edge
        step(4'b0000, 2'd0, 1'b1, "R6");
        step(4'b0110, 2'd0, 1'b0, "R6");
        step(4'b0000, 2'd0, 1'b0, "R6");
        step(4'b0000, 2'd0, 1'b1, "R6");
        idle(4'b0000, 4, "R6");

        // R2: select sweep over a fixed mixed pattern
        idle(4'b0101, 4, "R2");
        for (int s = 0; s < 4; s++) step(4'b0101, s[1:0], 1'b0, "R2");
        idle(4'b1010, 4, "R2");
        for (int s = 0; s < 4; s++) step(4'b1010, s[1:0], 1'b0, "R2");

        // Random mix: thermometer steps, arbitrary patterns, clears (R5, R2, R6)
        lvl = 4'b0000;
        for (int i = 0; i < 4000; i++) begin
            r = $urandom_range(0, 9);
            if (r < 4) begin
                v = lvl;
            end else if (r < 7) begin
                v   = lvl[0] ? fall_pat[$urandom_range(0, 3)] : rise_pat[$urandom_range(0, 3)];
                lvl = {4{v[3]}};
            end else begin
                v   = 4'($urandom);
                lvl = {4{v[3]}};
            end
            step(v, 2'($urandom), ($urandom_range(0, 15) == 0), "R5");
        end

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule